// File: doc/BRIEF.md
# Accumulator Rounding Stage

This block rounds a 40-bit fixed-point accumulator value to a kept word and registers the result. The operand is made of an 8-bit guard field (bits 39:32), a 16-bit kept word (bits 31:16) and a 16-bit fraction word (bits 15:0). When rounding is requested, the stage adds one half of the kept least significant bit and then forces every bit below the kept position to zero. Ties always go upward, toward positive infinity. They are not steered to an even value.

A two-bit scale mode moves the rounding position. The position follows the alignment the value would have if it were later shifted by one place in either direction. The stored value is never shifted: only the position of the added half and the width of the cleared field change. When no rounding is requested, the operand goes through the output register unchanged. The stage serves the plain round, multiply-and-round and multiply-accumulate-and-round operations of a datapath. Those operations drive the round-enable strobe.

Top module: `acc_round_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `acc_out` is zero and `out_vld` is low.
- R2: With `rnd_en` high and `scale_mode` = 2'b00, the output is (operand + 2^15) with bits 15:0 cleared. A fraction below 0x8000 leaves bits 39:16 unchanged, and a fraction above 0x8000 adds one at bit 16.
- R3: With `scale_mode` = 2'b00, a fraction word of exactly 0x8000 rounds up (one added at bit 16), whether bit 16 of the operand is 0 or 1.
- R4: With `rnd_en` high and `scale_mode` = 2'b01 (scale down), the output is (operand + 2^16) with bits 16:0 cleared.
- R5: With `rnd_en` high and `scale_mode` = 2'b10 (scale up), the output is (operand + 2^14) with bits 14:0 cleared.
- R6: `scale_mode` = 2'b11 behaves exactly like 2'b00.
- R7: The carry of the rounding addition runs through the kept word into the guard field. The 40-bit sum wraps modulo 2^40 without saturation.
- R8: With `rnd_en` low, `acc_out` equals the operand of the previous cycle for every `scale_mode` value, and `out_vld` is low.
- R9: `acc_out` and `out_vld` are registered. `out_vld` is high in exactly the cycle after a cycle with `rnd_en` high.
- R10: Negative operands follow the same add-then-clear rule, so a value exactly half a kept LSB below a kept step rounds toward positive infinity (0xFF_FFFF_8000 becomes 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 40 | Accumulator operand |
| rnd_en | input | 1 | Round request for this cycle's operand |
| scale_mode | input | 2 | 00 none, 01 scale down, 10 scale up, 11 same as none |
| acc_out | output | 40 | Registered rounded or passed-through value |
| out_vld | output | 1 | High when acc_out holds a rounded result |

## Verification
Every result, rounded or passed through, is due one clock edge after the operand, strobe and mode are applied. The bench drives all three on a falling edge and samples `acc_out` and `out_vld` one nanosecond after the next rising edge, before new inputs go on. Each vector is checked against a behavioural add-then-clear model, or against a literal value worked out by hand for the tie, carry, wrap and negative cases. The embedded properties check the same one-edge relationship: the cleared bit field per mode, pass-through and the strobe-to-flag timing.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

    typedef enum logic [1:0] {
        SCL_NONE = 2'b00,
        SCL_DOWN = 2'b01,
        SCL_UP   = 2'b10,
        SCL_RSVD = 2'b11
    } scale_e;

endpackage

// File: rtl/rnd_pos_decode.sv
module rnd_pos_decode
    import acc_rnd_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int LO_W  = 16
) (
    input  scale_e             mode,
    output logic [ACC_W-1:0]   half_bit,
    output logic [ACC_W-1:0]   keep_mask
);
    localparam int POS_W    = $clog2(ACC_W);
    localparam int POS_NONE = LO_W - 1;
    localparam int POS_DOWN = LO_W;
    localparam int POS_UP   = LO_W - 2;

    logic [POS_W-1:0] pos;

    always_comb begin
        case (mode)
            SCL_DOWN: pos = POS_W'(POS_DOWN);
            SCL_UP:   pos = POS_W'(POS_UP);
            default:  pos = POS_W'(POS_NONE);
        endcase
    end

    for (genvar i = 0; i < ACC_W; i++) begin : g_bit
        assign half_bit[i]  = (int'(pos) == i);
        assign keep_mask[i] = (i > int'(pos));
    end

endmodule

// File: rtl/rnd_add_clear.sv
module rnd_add_clear #(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] operand,
    input  logic [ACC_W-1:0] half_bit,
    input  logic [ACC_W-1:0] keep_mask,
    output logic [ACC_W-1:0] rounded
);
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum     = operand + half_bit;   // wraps at ACC_W bits, no saturation
        rounded = sum & keep_mask;
    end

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
    import acc_rnd_pkg::*;
#(
    parameter int EXT_W = 8,
    parameter int HI_W  = 16,
    parameter int LO_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [EXT_W+HI_W+LO_W-1:0]  acc_in,
    input  logic                        rnd_en,
    input  logic [1:0]                  scale_mode,
    output logic [EXT_W+HI_W+LO_W-1:0]  acc_out,
    output logic                        out_vld
);
    localparam int ACC_W = EXT_W + HI_W + LO_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
    } stage_t;

    logic [ACC_W-1:0] half_bit;
    logic [ACC_W-1:0] keep_mask;
    logic [ACC_W-1:0] rounded;
    stage_t           stage_d, stage_q;

    rnd_pos_decode #(
        .ACC_W (ACC_W),
        .LO_W  (LO_W)
    ) u_pos (
        .mode      (scale_e'(scale_mode)),
        .half_bit  (half_bit),
        .keep_mask (keep_mask)
    );

    rnd_add_clear #(
        .ACC_W (ACC_W)
    ) u_add (
        .operand   (acc_in),
        .half_bit  (half_bit),
        .keep_mask (keep_mask),
        .rounded   (rounded)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = rnd_en;
        stage_d.acc = rnd_en ? rounded : acc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign acc_out = stage_q.acc;
    assign out_vld = stage_q.vld;

    AST_NONE_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en && (scale_mode == 2'b00)) |=> (acc_out[LO_W-1:0] == '0)); // R2
    AST_DOWN_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en && (scale_mode == 2'b01)) |=> (acc_out[LO_W:0] == '0)); // R4
    AST_UP_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en && (scale_mode == 2'b10)) |=> (acc_out[LO_W-2:0] == '0)); // R5
    AST_RSVD_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en && (scale_mode == 2'b11)) |=> (acc_out[LO_W-1:0] == '0)); // R6
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_en |=> (acc_out == $past(acc_in))); // R8
    AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_en |=> out_vld); // R9
    AST_NO_VLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_en |=> !out_vld); // R9

endmodule

// File: tb/tb_acc_round_unit.sv
`timescale 1ns/1ps
module tb_acc_round_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] acc_in = '0;
    logic        rnd_en = 1'b0;
    logic [1:0]  scale_mode = 2'b00;
    logic [39:0] acc_out;
    logic        out_vld;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_round_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_in     (acc_in),
        .rnd_en     (rnd_en),
        .scale_mode (scale_mode),
        .acc_out    (acc_out),
        .out_vld    (out_vld)
    );

    function automatic logic [39:0] ref_round(logic [39:0] x, logic [1:0] m);
        logic [39:0] half;
        half = (m == 2'b01) ? 40'h1_0000 : (m == 2'b10) ? 40'h4000 : 40'h8000;
        return (x + half) & ~((half << 1) - 40'd1);
    endfunction

    task automatic check(string req, logic [39:0] got_v, logic [39:0] exp_v,
                         logic got_f, logic exp_f);
        n_run++;
        if (got_v !== exp_v || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: acc_out=%h vld=%b expected acc_out=%h vld=%b",
                     req, got_v, got_f, exp_v, exp_f);
        end
    endtask

    task automatic apply(string req, logic [39:0] x, logic en, logic [1:0] m,
                         logic [39:0] exp_v);
        @(negedge clk);
        acc_in = x; rnd_en = en; scale_mode = m;
        @(posedge clk);
        #1;
        check(req, acc_out, exp_v, out_vld, en);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: acc_out=%h expected completion", acc_out);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", acc_out, 40'h0, out_vld, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", acc_out, 40'h0, out_vld, 1'b0);

        apply("R2", 40'h00_1234_7FFF, 1'b1, 2'b00, 40'h00_1234_0000);
        apply("R2", 40'h00_1234_8001, 1'b1, 2'b00, 40'h00_1235_0000);
        apply("R3", 40'h00_1234_8000, 1'b1, 2'b00, 40'h00_1235_0000);
        apply("R3", 40'h00_1235_8000, 1'b1, 2'b00, 40'h00_1236_0000);
        apply("R4", 40'h00_1234_FFFF, 1'b1, 2'b01, 40'h00_1234_0000);
        apply("R4", 40'h00_1235_0000, 1'b1, 2'b01, 40'h00_1236_0000);
        apply("R5", 40'h00_0000_4000, 1'b1, 2'b10, 40'h00_0000_8000);
        apply("R5", 40'h00_0000_3FFF, 1'b1, 2'b10, 40'h00_0000_0000);
        apply("R6", 40'h00_1234_8000, 1'b1, 2'b11, 40'h00_1235_0000);
        apply("R6", 40'h00_1234_7FFF, 1'b1, 2'b11, 40'h00_1234_0000);
        apply("R7", 40'h7F_FFFF_8000, 1'b1, 2'b00, 40'h80_0000_0000);
        apply("R7", 40'hFF_FFFF_8000, 1'b1, 2'b00, 40'h00_0000_0000);
        apply("R10", 40'hFF_FFFE_8000, 1'b1, 2'b00, 40'hFF_FFFF_0000);
        apply("R10", 40'hFF_FFFE_7FFF, 1'b1, 2'b00, 40'hFF_FFFE_0000);
        for (int m = 0; m < 4; m++) begin
            apply("R8", 40'h5A_A5C3_8765, 1'b0, 2'(m), 40'h5A_A5C3_8765);
        end
        apply("R9", 40'h00_0001_8000, 1'b1, 2'b00, 40'h00_0002_0000);
        apply("R9", 40'h00_0001_8000, 1'b0, 2'b00, 40'h00_0001_8000);

        for (int k = 0; k < 400; k++) begin
            logic [39:0] x;
            logic [1:0]  m;
            logic        en;
            x  = {8'($urandom), $urandom};
            m  = 2'($urandom);
            en = ($urandom % 4) != 0;
            if (en) begin
                case (m)
                    2'b00: apply("R2", x, en, m, ref_round(x, m));
                    2'b01: apply("R4", x, en, m, ref_round(x, m));
                    2'b10: apply("R5", x, en, m, ref_round(x, m));
                    default: apply("R6", x, en, m, ref_round(x, m));
                endcase
            end else begin
                apply("R8", x, en, m, x);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule